// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a set of interrupt request lines into a single interrupt output for a host processor. When the host acknowledges, the block picks the winning request and returns an 8-bit vector. The vector is the programmed base with the request number in its low bits. Three per-line registers track the state of each line: a pending register, an in-service register and a mask register. A request that is in service holds off every request of equal or lower priority until software retires it.

Software configures the block through a simple write port and can read state through a combinational read port, using the same 3-bit address space. The settings it can program are:
- the vector base;
- a trigger mode for each line, edge or level;
- the mask bits;
- fixed or rotating priority;
- automatic end-of-interrupt.

A write to the command address retires the highest-priority level that is in service. If an acknowledge arrives when no request is eligible, for example because a level request was withdrawn, the block answers with a spurious vector for the lowest level. That answer changes no state.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After synchronous reset, int_out is 0 and vector_out is 0. Pending, in-service, mask, trigger, base and control all read 0, so every line is edge-triggered under fixed priority.
- R2: A line whose trigger bit (write address 1) is 0 becomes pending only on a 0-to-1 change of its input. A line held high after its acknowledge does not become pending again.
- R3: A line whose trigger bit is 1 has a pending bit that follows its input level. The bit clears when the input drops, is cleared by the acknowledge that grants it, and sets again while the input stays high.
- R4: A mask bit of 1 (write address 2) keeps that line from raising int_out or being granted, but its pending bit is kept. Clearing the mask bit lets the request raise int_out again.
- R5: In fixed priority, line 0 is highest and line N-1 is lowest.
- R6: Write address 0 sets the base. On the clock edge that samples ack_in high, vector_out becomes the base bits above log2(N) followed by the granted level in the low bits. vector_out holds its value otherwise.
- R7: A granted acknowledge clears the winner's pending bit and sets its in-service bit. Read address 5 returns pending, 6 returns in-service, 2 mask, 1 trigger, 0 base, and 3 returns control with bit 1 = auto-EOI and bit 0 = rotate.
- R8: int_out is high exactly when some unmasked pending line ranks above every line that is in service. This allows a higher-priority request to nest over one being serviced.
- R9: A write to address 4, with any data, clears the in-service bit of the highest-priority level in service. It does nothing if none is in service.
- R10: With control bit 1 set, a granted acknowledge returns the vector but leaves the in-service register unchanged.
- R11: An acknowledge while int_out is low returns the base with all low bits set, which is level N-1. Pending and in-service are left unchanged.
- R12: With control bit 0 set, a level whose in-service bit is released (by command or automatically) becomes the lowest priority and the next index up becomes the highest. After reset, level N-1 is lowest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ | Interrupt request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration write address |
| cfg_wdata | input | DATA_W | Configuration write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | DATA_W | Read data, combinational |
| ack_in | input | 1 | Interrupt acknowledge strobe, one cycle |
| int_out | output | 1 | Interrupt request to the host |
| vector_out | output | VEC_W | Vector latched on acknowledge |

## Verification
The bench builds the block with eight lines, an 8-bit vector and 8-bit data, so three low vector bits carry the level and five bits carry the base. With eight lines, a rotation can be driven through its wrap from level 7 back to level 0 in a handful of acknowledges. The same setting lets a spurious answer be told apart from a real grant of level 7 by reading the in-service register. The widths also allow nesting three deep, masked lines and lines switched between edge and level trigger to be mixed within one short run.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int unsigned PIC_ADDR_W = 3;

    // Register address map shared by the write and read ports
    typedef enum logic [PIC_ADDR_W-1:0] {
        PIC_A_BASE = 3'd0,
        PIC_A_TRIG = 3'd1,
        PIC_A_MASK = 3'd2,
        PIC_A_CTRL = 3'd3,
        PIC_A_EOI  = 3'd4,
        PIC_A_PEND = 3'd5,
        PIC_A_INSV = 3'd6,
        PIC_A_RSVD = 3'd7
    } pic_addr_e;

    typedef struct packed {
        logic auto_eoi;
        logic rotate;
    } pic_ctrl_t;

    // Outcome of an acknowledge cycle
    typedef enum logic [1:0] {
        ACK_NONE  = 2'd0,
        ACK_GRANT = 2'd1,
        ACK_SPUR  = 2'd2
    } pic_ack_e;

    function automatic pic_ctrl_t pic_decode_ctrl(input logic [1:0] bits);
        pic_ctrl_t c;
        c.rotate   = bits[0];
        c.auto_eoi = bits[1];
        return c;
    endfunction

    function automatic logic pic_is_addr(input logic we,
                                         input logic [PIC_ADDR_W-1:0] a,
                                         input pic_addr_e target);
        return we && (pic_addr_e'(a) == target);
    endfunction

endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
    import pic_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 8,
    parameter int unsigned VEC_W   = 8,
    parameter int unsigned DATA_W  = 8,
    localparam int unsigned LVL_W  = $clog2(NUM_IRQ),
    localparam int unsigned BASE_W = VEC_W - LVL_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [PIC_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [BASE_W-1:0]     base_q,
    output logic [NUM_IRQ-1:0]    trig_q,
    output logic [NUM_IRQ-1:0]    mask_q,
    output pic_ctrl_t             ctrl_q,
    output logic                  eoi_cmd
);

    assign eoi_cmd = pic_is_addr(we, addr, PIC_A_EOI);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            trig_q <= '0;
            mask_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (pic_is_addr(we, addr, PIC_A_BASE)) base_q <= wdata[VEC_W-1:LVL_W];
            if (pic_is_addr(we, addr, PIC_A_TRIG)) trig_q <= wdata[NUM_IRQ-1:0];
            if (pic_is_addr(we, addr, PIC_A_MASK)) mask_q <= wdata[NUM_IRQ-1:0];
            if (pic_is_addr(we, addr, PIC_A_CTRL)) ctrl_q <= pic_decode_ctrl(wdata[1:0]);
        end
    end

endmodule

// File: rtl/pic_req_capture.sv
module pic_req_capture #(
    parameter int unsigned NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [NUM_IRQ-1:0] level_mode,
    input  logic [NUM_IRQ-1:0] grant_clr,
    output logic [NUM_IRQ-1:0] pend_q
);

    logic [NUM_IRQ-1:0] irq_prev_q;

    always_ff @(posedge clk) begin
        if (rst) irq_prev_q <= '0;
        else     irq_prev_q <= irq_in;
    end

    // One capture cell per line; trigger style picked per line at run time
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        logic rise;
        logic nxt;
        assign rise = irq_in[i] & ~irq_prev_q[i];

        always_comb begin
            if (level_mode[i]) nxt = irq_in[i] & ~grant_clr[i];
            else               nxt = (pend_q[i] & ~grant_clr[i]) | rise;
        end

        always_ff @(posedge clk) begin
            if (rst) pend_q[i] <= 1'b0;
            else     pend_q[i] <= nxt;
        end
    end

endmodule

// File: rtl/pic_prio_find.sv
module pic_prio_find #(
    parameter int unsigned NUM_IRQ = 8,
    localparam int unsigned LVL_W  = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0] vec,
    input  logic [LVL_W-1:0]   start,
    output logic               found,
    output logic [LVL_W-1:0]   lvl,
    output logic [LVL_W-1:0]   rank
);

    // Scan from the lowest rank upward so the highest rank seen last wins
    always_comb begin
        found = 1'b0;
        lvl   = '0;
        rank  = '0;
        for (int k = NUM_IRQ - 1; k >= 0; k--) begin
            logic [LVL_W-1:0] idx;
            idx = start + LVL_W'(k);
            if (vec[idx]) begin
                found = 1'b1;
                lvl   = idx;
                rank  = LVL_W'(k);
            end
        end
    end

endmodule

// File: rtl/pic_service.sv
module pic_service
    import pic_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 8,
    parameter int unsigned VEC_W   = 8,
    localparam int unsigned LVL_W  = $clog2(NUM_IRQ),
    localparam int unsigned BASE_W = VEC_W - LVL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  pic_ack_e           ack_kind,
    input  logic [LVL_W-1:0]   win_lvl,
    input  logic               eoi_cmd,
    input  logic               top_found,
    input  logic [LVL_W-1:0]   top_lvl,
    input  pic_ctrl_t          ctrl,
    input  logic [BASE_W-1:0]  base,
    output logic [NUM_IRQ-1:0] isr_q,
    output logic [LVL_W-1:0]   lowest_q,
    output logic [VEC_W-1:0]   vector_q
);

    logic [NUM_IRQ-1:0] isr_nxt;
    logic [LVL_W-1:0]   low_nxt;

    // Command release first, then the acknowledge, so an automatic
    // release in the same cycle sets the rotation point
    always_comb begin
        isr_nxt = isr_q;
        low_nxt = lowest_q;
        if (eoi_cmd && top_found) begin
            isr_nxt[top_lvl] = 1'b0;
            if (ctrl.rotate) low_nxt = top_lvl;
        end
        if (ack_kind == ACK_GRANT) begin
            if (ctrl.auto_eoi) begin
                if (ctrl.rotate) low_nxt = win_lvl;
            end else begin
                isr_nxt[win_lvl] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q    <= '0;
            lowest_q <= LVL_W'(NUM_IRQ - 1);
            vector_q <= '0;
        end else begin
            isr_q    <= isr_nxt;
            lowest_q <= low_nxt;
            case (ack_kind)
                ACK_GRANT: vector_q <= {base, win_lvl};
                ACK_SPUR:  vector_q <= {base, {LVL_W{1'b1}}};
                default:   vector_q <= vector_q;
            endcase
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import pic_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 8,
    parameter int unsigned VEC_W   = 8,
    parameter int unsigned DATA_W  = 8,
    localparam int unsigned LVL_W  = $clog2(NUM_IRQ),
    localparam int unsigned BASE_W = VEC_W - LVL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic [2:0]         rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               ack_in,
    output logic               int_out,
    output logic [VEC_W-1:0]   vector_out
);

    logic [BASE_W-1:0]  base_q;
    logic [NUM_IRQ-1:0] trig_q;
    logic [NUM_IRQ-1:0] mask_q;
    pic_ctrl_t          ctrl_q;
    logic               eoi_cmd;
    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] isr_q;
    logic [LVL_W-1:0]   lowest_q;
    logic [LVL_W-1:0]   start;
    logic [NUM_IRQ-1:0] eligible;
    logic               req_found, top_found;
    logic [LVL_W-1:0]   req_lvl, req_rank, top_lvl, top_rank;
    logic               serve_ok;
    pic_ack_e           ack_kind;
    logic [NUM_IRQ-1:0] grant_clr;
    logic               auto_eoi_w;

    pic_cfg_regs #(
        .NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W), .DATA_W(DATA_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .base_q(base_q), .trig_q(trig_q), .mask_q(mask_q), .ctrl_q(ctrl_q),
        .eoi_cmd(eoi_cmd)
    );

    pic_req_capture #(.NUM_IRQ(NUM_IRQ)) u_req (
        .clk(clk), .rst(rst), .irq_in(irq_in), .level_mode(trig_q),
        .grant_clr(grant_clr), .pend_q(pend_q)
    );

    // Rank 0 sits just above the current lowest level when rotating
    assign start    = ctrl_q.rotate ? LVL_W'(lowest_q + 1'b1) : '0;
    assign eligible = pend_q & ~mask_q;

    pic_prio_find #(.NUM_IRQ(NUM_IRQ)) u_find_req (
        .vec(eligible), .start(start),
        .found(req_found), .lvl(req_lvl), .rank(req_rank)
    );

    pic_prio_find #(.NUM_IRQ(NUM_IRQ)) u_find_isr (
        .vec(isr_q), .start(start),
        .found(top_found), .lvl(top_lvl), .rank(top_rank)
    );

    assign serve_ok   = req_found && (!top_found || (req_rank < top_rank));
    assign int_out    = serve_ok;
    assign ack_kind   = !ack_in ? ACK_NONE : (serve_ok ? ACK_GRANT : ACK_SPUR);
    assign auto_eoi_w = ctrl_q.auto_eoi;

    always_comb begin
        grant_clr = '0;
        if (ack_kind == ACK_GRANT) grant_clr[req_lvl] = 1'b1;
    end

    pic_service #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) u_svc (
        .clk(clk), .rst(rst), .ack_kind(ack_kind), .win_lvl(req_lvl),
        .eoi_cmd(eoi_cmd), .top_found(top_found), .top_lvl(top_lvl),
        .ctrl(ctrl_q), .base(base_q),
        .isr_q(isr_q), .lowest_q(lowest_q), .vector_q(vector_out)
    );

    always_comb begin
        case (pic_addr_e'(rd_addr))
            PIC_A_BASE: rd_data = DATA_W'({base_q, {LVL_W{1'b0}}});
            PIC_A_TRIG: rd_data = DATA_W'(trig_q);
            PIC_A_MASK: rd_data = DATA_W'(mask_q);
            PIC_A_CTRL: rd_data = DATA_W'({ctrl_q.auto_eoi, ctrl_q.rotate});
            PIC_A_PEND: rd_data = DATA_W'(pend_q);
            PIC_A_INSV: rd_data = DATA_W'(isr_q);
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
    import pic_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 8,
    parameter int unsigned VEC_W   = 8,
    localparam int unsigned LVL_W  = $clog2(NUM_IRQ)
) (
    input logic               clk,
    input logic               rst,
    input logic               ack_in,
    input logic               int_out,
    input logic [VEC_W-1:0]   vector_out,
    input logic               cfg_we,
    input logic [2:0]         cfg_addr,
    input logic [NUM_IRQ-1:0] pend,
    input logic [NUM_IRQ-1:0] isr,
    input logic [NUM_IRQ-1:0] mask,
    input logic               auto_eoi
);

    logic eoi_wr;
    assign eoi_wr = cfg_we && (pic_addr_e'(cfg_addr) == PIC_A_EOI);

    AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((pend & ~mask) != '0)); // R4

    AST_GRANT_SETS_ISR: assert property (@(posedge clk) disable iff (rst)
        (ack_in && int_out && !auto_eoi && !eoi_wr)
        |=> ($countones(isr) == $countones($past(isr)) + 1)); // R7

    AST_EOI_CLEARS_ONE: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && !ack_in && (isr != '0))
        |=> ($countones(isr) + 1 == $countones($past(isr)))); // R9

    AST_AUTO_KEEPS_ISR: assert property (@(posedge clk) disable iff (rst)
        (ack_in && int_out && auto_eoi && !eoi_wr) |=> (isr == $past(isr))); // R10

    AST_SPUR_KEEPS_ISR: assert property (@(posedge clk) disable iff (rst)
        (ack_in && !int_out && !eoi_wr) |=> (isr == $past(isr))); // R11

    AST_SPUR_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (ack_in && !int_out) |=> (&vector_out[LVL_W-1:0])); // R11

    AST_VECTOR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ack_in && !$past(rst)) |=> $stable(vector_out)); // R6

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst(rst), .ack_in(ack_in), .int_out(int_out),
    .vector_out(vector_out), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .pend(pend_q), .isr(isr_q), .mask(mask_q), .auto_eoi(auto_eoi_w)
);

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;

    localparam int N  = 8;
    localparam int VW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_in = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [2:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          ack_in = 1'b0;
    logic          int_out;
    logic [VW-1:0] vector_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_vector_ctrl #(.NUM_IRQ(N), .VEC_W(VW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_addr(rd_addr),
        .rd_data(rd_data), .ack_in(ack_in), .int_out(int_out),
        .vector_out(vector_out)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_pend, m_isr, m_mask, m_trig, m_prev, m_base, m_vec;
    bit         m_rot, m_aeoi;
    int         m_low;

    function automatic int m_rank(input int l);
        int s;
        s = m_rot ? (m_low + 1) % N : 0;
        return (l - s + N) % N;
    endfunction

    function automatic int m_best(input logic [7:0] v);
        int b;
        b = -1;
        for (int l = 0; l < N; l++)
            if (v[l] && (b < 0 || m_rank(l) < m_rank(b))) b = l;
        return b;
    endfunction

    function automatic bit m_grant();
        int w, t;
        w = m_best(m_pend & ~m_mask);
        t = m_best(m_isr);
        return (w >= 0) && (t < 0 || m_rank(w) < m_rank(t));
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_base & 8'hF8;
            3'd1: return m_trig;
            3'd2: return m_mask;
            3'd3: return {6'd0, m_aeoi, m_rot};
            3'd5: return m_pend;
            3'd6: return m_isr;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        int w, t;
        bit g;
        logic [7:0] clr;
        if (rst) begin
            m_pend = 0; m_isr = 0; m_mask = 0; m_trig = 0; m_prev = 0;
            m_base = 0; m_vec = 0; m_rot = 0; m_aeoi = 0; m_low = N - 1;
        end else begin
            w = m_best(m_pend & ~m_mask);
            t = m_best(m_isr);
            g = m_grant();
            clr = 0;
            if (cfg_we && cfg_addr == 3'd4 && t >= 0) begin
                m_isr[t] = 1'b0;
                if (m_rot) m_low = t;
            end
            if (ack_in) begin
                if (g) begin
                    m_vec = (m_base & 8'hF8) | 8'(w);
                    clr[w] = 1'b1;
                    if (m_aeoi) begin
                        if (m_rot) m_low = w;
                    end else m_isr[w] = 1'b1;
                end else begin
                    m_vec = (m_base & 8'hF8) | 8'h07;
                end
            end
            for (int i = 0; i < N; i++) begin
                if (m_trig[i]) m_pend[i] = irq_in[i] && !clr[i];
                else m_pend[i] = (m_pend[i] && !clr[i]) || (irq_in[i] && !m_prev[i]);
            end
            m_prev = irq_in;
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: m_base = cfg_wdata;
                    3'd1: m_trig = cfg_wdata;
                    3'd2: m_mask = cfg_wdata;
                    3'd3: begin m_rot = cfg_wdata[0]; m_aeoi = cfg_wdata[1]; end
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(32'(int_out), 32'(m_grant()), "R8 int_out against model");
            check(32'(vector_out), 32'(m_vec), "R6 vector_out against model");
            check(32'(rd_data), 32'(m_read(rd_addr)), "R7 read port against model");
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic ack();
        ack_in = 1'b1;
        @(posedge clk); #1;
        ack_in = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, input logic [7:0] exp, input string tag);
        rd_addr = a;
        #1;
        check(32'(rd_data), 32'(exp), tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        #1;
        check(32'(int_out), 0, "R1 int_out after reset");
        check(32'(vector_out), 0, "R1 vector after reset");
        peek(3'd5, 8'h00, "R1 pending after reset");
        peek(3'd6, 8'h00, "R1 in-service after reset");
        peek(3'd2, 8'h00, "R1 mask after reset");

        // R2: edge capture
        irq_in = 8'h08; idle(1);
        peek(3'd5, 8'h08, "R2 edge sets pending");
        check(32'(int_out), 1, "R8 int raised by line 3");
        ack();
        check(32'(vector_out), 8'h03, "R6 vector for line 3");
        peek(3'd6, 8'h08, "R7 in-service set on grant");
        peek(3'd5, 8'h00, "R7 pending cleared on grant");
        idle(3);
        peek(3'd5, 8'h00, "R2 held-high line not pending again");
        wr(3'd4, 8'h00);
        peek(3'd6, 8'h00, "R9 EOI clears line 3");
        irq_in = 8'h00; idle(1);

        // R5 / R8 / R9: fixed priority and nesting
        irq_in = 8'h24; idle(1);
        ack();
        check(32'(vector_out), 8'h02, "R5 line 2 beats line 5");
        #1 check(32'(int_out), 0, "R8 lower line 5 held off by line 2");
        irq_in = 8'h25; idle(1);
        check(32'(int_out), 1, "R8 line 0 nests over line 2");
        ack();
        check(32'(vector_out), 8'h00, "R5 nested grant of line 0");
        peek(3'd6, 8'h05, "R7 two levels in service");
        wr(3'd4, 8'h00);
        peek(3'd6, 8'h04, "R9 EOI retires highest level 0 first");
        wr(3'd4, 8'h00);
        peek(3'd6, 8'h00, "R9 EOI retires level 2");
        check(32'(int_out), 1, "R8 line 5 now eligible");
        ack();
        check(32'(vector_out), 8'h05, "R6 vector for line 5");
        wr(3'd4, 8'h00);
        irq_in = 8'h00; idle(1);

        // R4 / R6 / R11: base, mask, spurious on masked request
        wr(3'd0, 8'h40);
        wr(3'd2, 8'h10);
        irq_in = 8'h10; idle(1);
        check(32'(int_out), 0, "R4 masked line keeps int low");
        peek(3'd5, 8'h10, "R4 masked line stays pending");
        ack();
        check(32'(vector_out), 8'h47, "R11 spurious vector with base 0x40");
        peek(3'd6, 8'h00, "R11 spurious leaves in-service clear");
        peek(3'd5, 8'h10, "R11 spurious leaves pending");
        wr(3'd2, 8'h00);
        check(32'(int_out), 1, "R4 unmask raises int");
        ack();
        check(32'(vector_out), 8'h44, "R6 base plus level 4");
        wr(3'd4, 8'h00);
        irq_in = 8'h00; idle(1);

        // R3 / R11: level trigger and withdrawn request
        wr(3'd1, 8'h02);
        irq_in = 8'h02; idle(1);
        peek(3'd5, 8'h02, "R3 level sets pending");
        irq_in = 8'h00; idle(1);
        peek(3'd5, 8'h00, "R3 level drop clears pending");
        ack();
        check(32'(vector_out), 8'h47, "R11 withdrawn request gives spurious");
        peek(3'd6, 8'h00, "R11 no in-service after spurious");
        irq_in = 8'h02; idle(1);
        ack();
        check(32'(vector_out), 8'h41, "R3 level line granted");
        peek(3'd5, 8'h00, "R3 grant clears level pending");
        idle(1);
        peek(3'd5, 8'h02, "R3 held level pends again");
        irq_in = 8'h00;
        wr(3'd4, 8'h00);
        wr(3'd1, 8'h00);

        // R10: automatic end of interrupt
        wr(3'd3, 8'h02);
        irq_in = 8'h40; idle(1);
        ack();
        check(32'(vector_out), 8'h46, "R10 auto-EOI vector");
        peek(3'd6, 8'h00, "R10 auto-EOI leaves in-service clear");
        irq_in = 8'h00;
        wr(3'd3, 8'h00);

        // R12: rotating priority
        wr(3'd3, 8'h01);
        irq_in = 8'h04; idle(1);
        ack();
        check(32'(vector_out), 8'h42, "R12 first grant line 2");
        wr(3'd4, 8'h00);
        irq_in = 8'h0A; idle(1);
        ack();
        check(32'(vector_out), 8'h43, "R12 line 3 above line 1 after rotation");
        wr(3'd4, 8'h00);
        ack();
        check(32'(vector_out), 8'h41, "R12 line 1 granted next");
        wr(3'd4, 8'h00);
        irq_in = 8'h81; idle(1);
        ack();
        check(32'(vector_out), 8'h47, "R12 line 7 above line 0 after rotation");
        peek(3'd6, 8'h80, "R12 real grant of line 7 in service");
        wr(3'd4, 8'h00);
        ack();
        check(32'(vector_out), 8'h40, "R12 rotation wraps to line 0");
        wr(3'd4, 8'h00);
        peek(3'd6, 8'h00, "R9 all levels retired");
        irq_in = 8'h00;
        idle(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule